// File: doc/BRIEF.md
# Aligned Vector Move Execution Unit

This unit carries out one packed aligned move per decoded operation. It holds sixteen 256-bit vector registers. It moves data between two of these registers, from memory into a register, or from a register out to memory. The decoder in front of it supplies the following fields: an opcode byte, an encoding class, a 4-bit reserved field, two 4-bit register selectors, a flag that says whether the second selector names memory, and an effective byte address.

Operations enter through a valid/ready handshake. An operation is taken on the rising edge where `op_valid` and `op_ready` are both high. `op_ready` stays low while a memory operation is in flight, so the upstream stage must hold its operation until it is taken.

Memory traffic leaves on a request channel with its own valid/ready handshake. Once `mem_req_valid` rises, the request fields stay fixed until `mem_req_ready` is seen high on a rising edge. Memory may apply back-pressure for any number of cycles. Load data is taken from `mem_rd_data` on that same handshake edge.

Operations that are rejected are reported as single-cycle pulses on two fault outputs. A rejected operation changes no state.

Top module: `vec_amove_unit`

## Requirements
- R1: After reset, `op_ready` is 1, `busy`, `fault_gp`, `fault_ud` and `mem_req_valid` are 0, and every register reads as zero.
- R2: Opcode 8'h28 writes the register named by `op_reg_idx` from the second operand: register `op_rm_idx`, or memory when `op_rm_is_mem` is 1. Opcode 8'h29 moves the `op_reg_idx` register into the second operand: register `op_rm_idx`, or memory.
- R3: Encoding 2'b00 (legacy, 128-bit) writes only bits 127:0 of the destination register. Bits 255:128 keep their old value.
- R4: Encoding 2'b01 (VEX-coded, 128-bit) writes bits 127:0 of the destination register and clears bits 255:128.
- R5: Encoding 2'b10 (VEX-coded, 256-bit) copies all 256 bits.
- R6: A store raises `mem_req_write`=1. In a 128-bit encoding it sets `mem_req_wide`=0 and drives `mem_req_wdata[255:128]` to zero. In the 256-bit encoding it sets `mem_req_wide`=1 and drives all 256 bits. A load raises `mem_req_write`=0.
- R7: A memory operand with a nonzero `op_addr[3:0]` in a 128-bit encoding, or a nonzero `op_addr[4:0]` in the 256-bit encoding, raises `fault_gp`.
- R8: `fault_ud` is raised in three cases: the opcode is neither 8'h28 nor 8'h29; the encoding is 2'b11; or the encoding is 2'b01 or 2'b10 and `op_vvvv` is not 4'b1111. The legacy encoding ignores `op_vvvv`.
- R9: A fault pulses high for exactly the one cycle after its operation is taken. When both faults apply, only `fault_ud` rises.
- R10: A faulting operation writes no register and issues no memory request.
- R11: A register-to-register move updates its destination on the edge that takes it, and `op_ready` stays high.
- R12: A memory operation holds `busy`=1 and `op_ready`=0 from the cycle after it is taken until the cycle after the memory handshake. The request fields stay stable while `mem_req_ready` is low. A load writes its register on the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation |
| op_code | input | 8 | Opcode byte |
| op_enc | input | 2 | Encoding class: 00 legacy-128, 01 VEX-128, 10 VEX-256 |
| op_vvvv | input | 4 | Reserved field, must be all ones in VEX-coded classes |
| op_reg_idx | input | 4 | Register selector (reg field) |
| op_rm_idx | input | 4 | Second-operand register selector |
| op_rm_is_mem | input | 1 | Second operand is memory |
| op_addr | input | 32 | Effective byte address of the memory operand |
| busy | output | 1 | Memory operation in flight |
| fault_gp | output | 1 | Alignment fault pulse |
| fault_ud | output | 1 | Undefined-operation fault pulse |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_wide | output | 1 | 1 = 32-byte access, 0 = 16-byte access |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 256 | Store data |
| mem_rd_data | input | 256 | Load data, taken at the handshake |

## Verification
The hardest case to reach from the ports is the upper-lane policy. A register's bits 255:128 can only be seen by storing that register in the 256-bit class, and they only hold a distinctive value after a wide load. Each lane test therefore loads known 256-bit patterns into both the source and destination registers first. It then runs the 128-bit move under test and reads the destination back with a wide store, so that a preserved half and a cleared half give different results. The memory-port stimulus holds `mem_req_ready` low for several cycles to check that the request stays stable. It also times `busy` against the handshake edge.

// File: rtl/vam_pkg.sv
package vam_pkg;
  localparam logic [1:0] ENC_LEG  = 2'b00;
  localparam logic [1:0] ENC_V128 = 2'b01;
  localparam logic [1:0] ENC_V256 = 2'b10;
  localparam logic [1:0] ENC_BAD  = 2'b11;

  localparam logic [7:0] OPC_TO_REG  = 8'h28;
  localparam logic [7:0] OPC_FROM_REG = 8'h29;

  localparam logic [3:0] VVVV_OK = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_FIN  = 2'b10
  } vam_state_e;
endpackage

// File: rtl/vam_decode.sv
module vam_decode
  import vam_pkg::*;
#(
  parameter int IW    = 4,
  parameter int AL_HI = 5,
  parameter int AL_LO = 4
) (
  input  logic [7:0]       code,
  input  logic [1:0]       enc,
  input  logic [3:0]       vvvv,
  input  logic [IW-1:0]    reg_idx,
  input  logic [IW-1:0]    rm_idx,
  input  logic             rm_is_mem,
  input  logic [AL_HI-1:0] addr_lo,
  output logic             ud,
  output logic             gp,
  output logic             is_mem,
  output logic             mem_write,
  output logic             wide,
  output logic [IW-1:0]    dst_idx,
  output logic [IW-1:0]    src_idx
);
  logic to_reg;
  logic known_op;
  logic vex_class;
  logic misaligned;

  always_comb begin
    to_reg     = (code == OPC_TO_REG);
    known_op   = to_reg || (code == OPC_FROM_REG);
    vex_class  = (enc == ENC_V128) || (enc == ENC_V256);
    wide       = (enc == ENC_V256);
    ud         = !known_op || (enc == ENC_BAD) || (vex_class && (vvvv != VVVV_OK));
    misaligned = wide ? (addr_lo != '0) : (addr_lo[AL_LO-1:0] != '0);
    gp         = !ud && rm_is_mem && misaligned;
    is_mem     = rm_is_mem;
    mem_write  = rm_is_mem && !to_reg;
    dst_idx    = to_reg ? reg_idx : rm_idx;
    src_idx    = to_reg ? rm_idx  : reg_idx;
  end
endmodule

// File: rtl/vam_regfile.sv
module vam_regfile
  import vam_pkg::*;
#(
  parameter int REGS = 16,
  parameter int VW   = 256,
  parameter int LANE = 128,
  localparam int IW  = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [VW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_enc,
  input  logic [VW-1:0] wr_data
);
  logic [VW-1:0] regs_q [REGS];
  logic [VW-1:0] old_val;
  logic [VW-1:0] merged;

  assign rd_data = regs_q[rd_idx];
  assign old_val = regs_q[wr_idx];

  always_comb begin
    case (wr_enc)
      ENC_V256: merged = wr_data;
      ENC_V128: merged = {{(VW-LANE){1'b0}}, wr_data[LANE-1:0]};
      default:  merged = {old_val[VW-1:LANE], wr_data[LANE-1:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= merged;
    end
  end

  for (genvar g = 0; g < REGS; g++) begin : g_lane_chk
    assert_keep_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(g) && wr_enc == ENC_LEG)
      |=> regs_q[g][VW-1:LANE] == $past(regs_q[g][VW-1:LANE]));
    assert_clear_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(g) && wr_enc == ENC_V128)
      |=> regs_q[g][VW-1:LANE] == '0);
    assert_full_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(g) && wr_enc == ENC_V256)
      |=> regs_q[g] == $past(wr_data));
  end
endmodule

// File: rtl/vam_seq.sv
module vam_seq
  import vam_pkg::*;
#(
  parameter int VW   = 256,
  parameter int LANE = 128,
  parameter int AW   = 32,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_fire,
  input  logic [1:0]    enc,
  input  logic [AW-1:0] addr,
  input  logic          d_ud,
  input  logic          d_gp,
  input  logic          d_is_mem,
  input  logic          d_mem_write,
  input  logic          d_wide,
  input  logic [IW-1:0] d_dst,
  input  logic [VW-1:0] src_data,
  output logic          idle,
  output logic          fault_gp,
  output logic          fault_ud,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic          mem_req_wide,
  output logic [AW-1:0] mem_req_addr,
  output logic [VW-1:0] mem_req_wdata,
  input  logic [VW-1:0] mem_rd_data,
  output logic          rf_wr_en,
  output logic [IW-1:0] rf_wr_idx,
  output logic [1:0]    rf_wr_enc,
  output logic [VW-1:0] rf_wr_data
);
  vam_state_e    state_q;
  logic          write_q;
  logic          wide_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] dst_q;
  logic [1:0]    enc_q;
  logic [VW-1:0] data_q;
  logic          clean;

  assign clean = op_fire && !d_ud && !d_gp;
  assign idle  = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      write_q  <= 1'b0;
      wide_q   <= 1'b0;
      addr_q   <= '0;
      dst_q    <= '0;
      enc_q    <= ENC_LEG;
      data_q   <= '0;
      fault_gp <= 1'b0;
      fault_ud <= 1'b0;
    end else begin
      fault_ud <= op_fire && d_ud;
      fault_gp <= op_fire && d_gp;
      case (state_q)
        ST_IDLE: begin
          if (clean && d_is_mem) begin
            state_q <= ST_REQ;
            write_q <= d_mem_write;
            wide_q  <= d_wide;
            addr_q  <= addr;
            dst_q   <= d_dst;
            enc_q   <= enc;
            data_q  <= d_wide ? src_data : {{(VW-LANE){1'b0}}, src_data[LANE-1:0]};
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            state_q <= ST_FIN;
            if (!write_q) data_q <= mem_rd_data;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state_q == ST_REQ);
    mem_req_write = write_q;
    mem_req_wide  = wide_q;
    mem_req_addr  = addr_q;
    mem_req_wdata = write_q ? data_q : '0;
    if (state_q == ST_FIN) begin
      rf_wr_en   = !write_q;
      rf_wr_idx  = dst_q;
      rf_wr_enc  = enc_q;
      rf_wr_data = data_q;
    end else begin
      rf_wr_en   = idle && clean && !d_is_mem;
      rf_wr_idx  = d_dst;
      rf_wr_enc  = enc;
      rf_wr_data = src_data;
    end
  end

  assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_gp && fault_ud));
  assert_fault_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_gp || fault_ud) |-> !mem_req_valid);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
  assert_req_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_wide ? (mem_req_addr[4:0] == '0) : (mem_req_addr[3:0] == '0)));
  assert_narrow_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !mem_req_wide) |-> (mem_req_wdata[VW-1:LANE] == '0));
endmodule

// File: rtl/vec_amove_unit.sv
module vec_amove_unit
  import vam_pkg::*;
#(
  parameter int REGS = 16,
  parameter int VW   = 256,
  parameter int LANE = 128,
  parameter int AW   = 32,
  localparam int IW    = $clog2(REGS),
  localparam int AL_HI = $clog2(VW / 8),
  localparam int AL_LO = $clog2(LANE / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [7:0]    op_code,
  input  logic [1:0]    op_enc,
  input  logic [3:0]    op_vvvv,
  input  logic [IW-1:0] op_reg_idx,
  input  logic [IW-1:0] op_rm_idx,
  input  logic          op_rm_is_mem,
  input  logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          fault_gp,
  output logic          fault_ud,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic          mem_req_wide,
  output logic [AW-1:0] mem_req_addr,
  output logic [VW-1:0] mem_req_wdata,
  input  logic [VW-1:0] mem_rd_data
);
  logic          d_ud, d_gp, d_is_mem, d_mem_write, d_wide;
  logic [IW-1:0] d_dst, d_src;
  logic [VW-1:0] src_data;
  logic          idle, op_fire;
  logic          rf_wr_en;
  logic [IW-1:0] rf_wr_idx;
  logic [1:0]    rf_wr_enc;
  logic [VW-1:0] rf_wr_data;

  assign op_ready = idle;
  assign busy     = !idle;
  assign op_fire  = op_valid && idle;

  vam_decode #(.IW(IW), .AL_HI(AL_HI), .AL_LO(AL_LO)) u_dec (
    .code(op_code), .enc(op_enc), .vvvv(op_vvvv),
    .reg_idx(op_reg_idx), .rm_idx(op_rm_idx), .rm_is_mem(op_rm_is_mem),
    .addr_lo(op_addr[AL_HI-1:0]),
    .ud(d_ud), .gp(d_gp), .is_mem(d_is_mem), .mem_write(d_mem_write),
    .wide(d_wide), .dst_idx(d_dst), .src_idx(d_src)
  );

  vam_regfile #(.REGS(REGS), .VW(VW), .LANE(LANE)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(d_src), .rd_data(src_data),
    .wr_en(rf_wr_en), .wr_idx(rf_wr_idx), .wr_enc(rf_wr_enc), .wr_data(rf_wr_data)
  );

  vam_seq #(.VW(VW), .LANE(LANE), .AW(AW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_fire(op_fire), .enc(op_enc), .addr(op_addr),
    .d_ud(d_ud), .d_gp(d_gp), .d_is_mem(d_is_mem), .d_mem_write(d_mem_write),
    .d_wide(d_wide), .d_dst(d_dst), .src_data(src_data),
    .idle(idle), .fault_gp(fault_gp), .fault_ud(fault_ud),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_wide(mem_req_wide),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rd_data(mem_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_enc(rf_wr_enc),
    .rf_wr_data(rf_wr_data)
  );

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !op_ready);
  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && (d_ud || d_gp)) |=> !mem_req_valid);
endmodule

// File: tb/vec_amove_unit_tb.sv
module vec_amove_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [7:0]   op_code = 8'h00;
  logic [1:0]   op_enc = 2'b00;
  logic [3:0]   op_vvvv = 4'hF;
  logic [3:0]   op_reg_idx = '0;
  logic [3:0]   op_rm_idx = '0;
  logic         op_rm_is_mem = 1'b0;
  logic [31:0]  op_addr = '0;
  logic         busy, fault_gp, fault_ud;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_req_write, mem_req_wide;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_req_wdata;
  logic [255:0] mem_rd_data = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vec_amove_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_enc(op_enc), .op_vvvv(op_vvvv),
    .op_reg_idx(op_reg_idx), .op_rm_idx(op_rm_idx), .op_rm_is_mem(op_rm_is_mem),
    .op_addr(op_addr), .busy(busy), .fault_gp(fault_gp), .fault_ud(fault_ud),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_wide(mem_req_wide),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rd_data(mem_rd_data)
  );

  // captured per operation
  logic         c_gp, c_ud, c_req, c_wr, c_wide, c_rdy_after, c_hold_ok;
  logic         c_fin_busy, c_after_busy, c_fault_next;
  logic [31:0]  c_addr;
  logic [255:0] c_wdata;

  localparam logic [255:0] PA = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
                                 64'h9999_aaaa_bbbb_cccc, 64'hdddd_eeee_ffff_0001};
  localparam logic [255:0] PB = {64'ha5a5_a5a5_0f0f_0f0f, 64'h1234_5678_9abc_def0,
                                 64'hfedc_ba98_7654_3210, 64'h0bad_cafe_dead_beef};

  task automatic check(input logic ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] code, input logic [1:0] enc, input logic [3:0] vv,
                        input logic [3:0] ri, input logic [3:0] mi, input logic mem,
                        input logic [31:0] a, input int dly, input logic [255:0] rdata);
    @(negedge clk);
    op_code = code; op_enc = enc; op_vvvv = vv; op_reg_idx = ri; op_rm_idx = mi;
    op_rm_is_mem = mem; op_addr = a; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    c_gp = fault_gp; c_ud = fault_ud; c_req = mem_req_valid; c_rdy_after = op_ready;
    c_hold_ok = 1'b1; c_fin_busy = 1'b0; c_after_busy = 1'b0;
    c_wr = mem_req_write; c_wide = mem_req_wide; c_addr = mem_req_addr; c_wdata = mem_req_wdata;
    if (c_req) begin
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        if (!mem_req_valid || mem_req_addr != c_addr || mem_req_wdata != c_wdata || op_ready)
          c_hold_ok = 1'b0;
      end
      mem_req_ready = 1'b1; mem_rd_data = rdata;
      @(negedge clk);
      mem_req_ready = 1'b0; mem_rd_data = '0;
      c_fin_busy = busy;
      @(negedge clk);
      c_after_busy = busy;
    end else begin
      @(negedge clk);
      c_fault_next = fault_gp | fault_ud;
    end
  endtask

  task automatic load_reg(input logic [3:0] idx, input logic [255:0] val);
    run_op(8'h28, 2'b10, 4'hF, idx, 4'd0, 1'b1, 32'h0000_0100, 0, val);
  endtask

  task automatic read_reg(input logic [3:0] idx, output logic [255:0] val);
    run_op(8'h29, 2'b10, 4'hF, idx, 4'd0, 1'b1, 32'h0000_0200, 0, '0);
    val = c_wdata;
  endtask

  task automatic t_reset();
    logic [255:0] v;
    check(op_ready === 1'b1 && busy === 1'b0, "R1 ready/busy", {op_ready, busy}, 2'b10);
    check(fault_gp === 1'b0 && fault_ud === 1'b0 && mem_req_valid === 1'b0,
          "R1 outputs idle", {fault_gp, fault_ud, mem_req_valid}, 0);
    read_reg(4'd9, v);
    check(v == '0, "R1 reg zero", v, '0);
  endtask

  task automatic t_mem_roundtrip();
    logic [255:0] v;
    run_op(8'h28, 2'b10, 4'hF, 4'd15, 4'd0, 1'b1, 32'h0000_0440, 3, PA);
    check(c_req && !c_wr && c_wide && c_addr == 32'h440, "R6 load request",
          {c_req, c_wr, c_wide, c_addr}, {3'b101, 32'h440});
    check(c_hold_ok, "R12 request stable under back-pressure", c_hold_ok, 1);
    check(!c_rdy_after && c_fin_busy && !c_after_busy, "R12 busy window",
          {c_rdy_after, c_fin_busy, c_after_busy}, 3'b010);
    run_op(8'h29, 2'b10, 4'hF, 4'd15, 4'd0, 1'b1, 32'h0000_0460, 2, '0);
    check(c_req && c_wr && c_wide && c_wdata == PA, "R6 wide store / R2 r15", c_wdata, PA);
  endtask

  task automatic t_legacy_copy();
    logic [255:0] v;
    load_reg(4'd1, PA); load_reg(4'd2, PB);
    run_op(8'h28, 2'b00, 4'h0, 4'd1, 4'd2, 1'b0, 32'h0, 0, '0);
    check(c_rdy_after && !c_gp && !c_ud, "R11 one-cycle copy keeps op_ready", c_rdy_after, 1);
    read_reg(4'd1, v);
    check(v == {PA[255:128], PB[127:0]}, "R3 legacy keeps upper", v, {PA[255:128], PB[127:0]});
  endtask

  task automatic t_v128_copy();
    logic [255:0] v;
    load_reg(4'd3, PA); load_reg(4'd4, PB);
    run_op(8'h29, 2'b01, 4'hF, 4'd4, 4'd3, 1'b0, 32'h0, 0, '0);
    read_reg(4'd3, v);
    check(v == {128'h0, PB[127:0]}, "R4 VEX128 clears upper / R2 29 dest rm", v, {128'h0, PB[127:0]});
  endtask

  task automatic t_v256_copy();
    logic [255:0] v;
    load_reg(4'd8, PA); load_reg(4'd5, PB);
    run_op(8'h28, 2'b10, 4'hF, 4'd8, 4'd5, 1'b0, 32'h0, 0, '0);
    read_reg(4'd8, v);
    check(v == PB, "R5 full copy / R2 28 dest reg", v, PB);
  endtask

  task automatic t_narrow_mem();
    logic [255:0] v;
    load_reg(4'd6, PA);
    run_op(8'h29, 2'b00, 4'h3, 4'd6, 4'd0, 1'b1, 32'h0000_0030, 1, '0);
    check(c_req && c_wr && !c_wide && c_addr == 32'h30 && c_wdata == {128'h0, PA[127:0]},
          "R6 narrow store", c_wdata, {128'h0, PA[127:0]});
    load_reg(4'd7, PA);
    run_op(8'h28, 2'b00, 4'hF, 4'd7, 4'd0, 1'b1, 32'h0000_0010, 0, PB);
    read_reg(4'd7, v);
    check(v == {PA[255:128], PB[127:0]}, "R3 legacy load keeps upper", v, {PA[255:128], PB[127:0]});
    run_op(8'h28, 2'b01, 4'hF, 4'd7, 4'd0, 1'b1, 32'h0000_0050, 0, PA);
    read_reg(4'd7, v);
    check(v == {128'h0, PA[127:0]}, "R4 VEX128 load clears upper", v, {128'h0, PA[127:0]});
  endtask

  task automatic t_align();
    logic [255:0] v;
    load_reg(4'd10, PA);
    run_op(8'h28, 2'b00, 4'hF, 4'd10, 4'd0, 1'b1, 32'h0000_0008, 0, PB);
    check(c_gp && !c_ud && !c_req, "R7 narrow misaligned gp, R10 no request",
          {c_gp, c_ud, c_req}, 3'b100);
    check(!c_fault_next, "R9 fault one cycle", c_fault_next, 0);
    read_reg(4'd10, v);
    check(v == PA, "R10 no register write on fault", v, PA);
    run_op(8'h29, 2'b10, 4'hF, 4'd10, 4'd0, 1'b1, 32'h0000_0010, 0, '0);
    check(c_gp && !c_req, "R7 wide store at 16-byte offset gp", {c_gp, c_req}, 2'b10);
    run_op(8'h29, 2'b10, 4'hF, 4'd10, 4'd0, 1'b1, 32'h0000_0020, 0, '0);
    check(!c_gp && c_req && c_wdata == PA, "R7 wide aligned ok", c_wdata, PA);
  endtask

  task automatic t_undef();
    logic [255:0] v;
    load_reg(4'd11, PA); load_reg(4'd12, PB);
    run_op(8'h28, 2'b01, 4'hE, 4'd11, 4'd12, 1'b0, 32'h0, 0, '0);
    check(c_ud && !c_gp, "R8 vvvv in VEX", {c_ud, c_gp}, 2'b10);
    read_reg(4'd11, v);
    check(v == PA, "R10 ud copy leaves dest", v, PA);
    run_op(8'h2A, 2'b00, 4'hF, 4'd11, 4'd12, 1'b0, 32'h0, 0, '0);
    check(c_ud, "R8 bad opcode", c_ud, 1);
    run_op(8'h28, 2'b11, 4'hF, 4'd11, 4'd12, 1'b0, 32'h0, 0, '0);
    check(c_ud, "R8 encoding 11", c_ud, 1);
    run_op(8'h28, 2'b10, 4'h7, 4'd11, 4'd0, 1'b1, 32'h0000_0004, 0, PB);
    check(c_ud && !c_gp && !c_req, "R9 ud wins over gp", {c_ud, c_gp, c_req}, 3'b100);
    run_op(8'h28, 2'b00, 4'h5, 4'd11, 4'd12, 1'b0, 32'h0, 0, '0);
    check(!c_ud && !c_gp, "R8 legacy ignores vvvv", {c_ud, c_gp}, 0);
    read_reg(4'd11, v);
    check(v == {PA[255:128], PB[127:0]}, "R8 legacy copy done", v, {PA[255:128], PB[127:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_roundtrip();
    t_legacy_copy();
    t_v128_copy();
    t_v256_copy();
    t_narrow_mem();
    t_align();
    t_undef();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule